// File: doc/BRIEF.md
# Swap-Driven Byte Permutation Builder

This block turns three 256-entry byte buffers into a bijective 256-entry byte substitution table. A run first writes the table with the identity mapping, value k at slot k. It then makes three passes over the index range 0 to 255. In each pass, every index whose source byte differs from the index swaps two table slots: the slot at the index and the slot named by the source byte. The first pass reads the C buffer, the second the B buffer and the last the A buffer.

The source buffers sit outside the block and are only read. Each one presents an address and returns its byte in the same cycle, so the generator that filled them can carry on from where it stopped. A one-cycle start pulse begins a run. `busy` stays high for the whole run, and `done` pulses once at the end. After that the finished table is read through a port with one cycle of latency.

Top module: `perm_swap_builder`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A `start` pulse while idle begins a run. `busy` is high from the cycle after the accepted edge until the run ends.
- R3: The table starts as the identity. Three passes then follow in the order C, B, A. Each pass steps the index i from 0 up to 255, and for every i where src(i) != i it exchanges table[i] and table[src(i)]. The final table matches this procedure exactly.
- R4: An index whose source byte equals the index takes one cycle and changes nothing. A swap takes two cycles. `done` is therefore high in the cycle that follows clock edge 1024 + S after the accepted start edge, where S is the number of swaps in the run.
- R5: `done` is a single-cycle pulse, and it is high in the first cycle in which `busy` is low again.
- R6: A `start` pulse while `busy` is high is ignored. It changes neither the run length nor the result.
- R7: The finished table holds every byte value exactly once.
- R8: `tbl_data` shows table[`tbl_addr`] one clock after the address is presented.
- R9: Every run rebuilds the table from the identity, whatever a previous run left in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, one cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| c_addr | output | 8 | Index into buffer C |
| c_data | input | 8 | Byte of buffer C at c_addr, same cycle |
| b_addr | output | 8 | Index into buffer B |
| b_data | input | 8 | Byte of buffer B at b_addr, same cycle |
| a_addr | output | 8 | Index into buffer A |
| a_data | input | 8 | Byte of buffer A at a_addr, same cycle |
| tbl_addr | input | 8 | Table read index |
| tbl_data | output | 8 | Table byte, one cycle after tbl_addr |

## Verification
The bench covers three kinds of source buffers. All-identity buffers make every index a skip; a bug that writes on a skip, or that spends two cycles on it, breaks either the result or the 1024-cycle run length. Single-entry chains whose outcome depends on the pass order expose a design that reads the buffers in the wrong order or takes the swap partners from the wrong buffer, because the resulting table is a different permutation. Pseudo-random buffers followed by a second run catch a stale table that was never re-initialised, a swap that copies one value instead of exchanging two (the table loses bijectivity), and a start pulse that restarts a run already in progress, which shows up as a wrong cycle count.

// File: rtl/perm_swap_builder.sv
module perm_swap_builder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] c_addr,
  input  logic [W-1:0] c_data,
  output logic [W-1:0] b_addr,
  input  logic [W-1:0] b_data,
  output logic [W-1:0] a_addr,
  input  logic [W-1:0] a_data,
  input  logic [W-1:0] tbl_addr,
  output logic [W-1:0] tbl_data
);
  localparam int N = 1 << W;
  localparam logic [W-1:0] LAST = W'(N - 1);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_RD, S_WR} state_t;

  state_t       state;
  logic [W-1:0] idx, sel, sel_r, vi, vj;
  logic [1:0]   pass;
  logic [W-1:0] tbl [N];

  assign busy   = (state != S_IDLE);
  assign c_addr = idx;
  assign b_addr = idx;
  assign a_addr = idx;
  assign sel    = (pass == 2'd0) ? c_data : (pass == 2'd1) ? b_data : a_data;

  wire at_end  = (idx == LAST);
  wire advance = (state == S_WR) || (state == S_RD && sel == idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      pass  <= '0;
      sel_r <= '0;
      vi    <= '0;
      vj    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_INIT;
          idx   <= '0;
        end
        S_INIT: begin
          idx <= idx + 1'b1;
          if (at_end) begin
            state <= S_RD;
            pass  <= '0;
          end
        end
        S_RD: if (sel != idx) begin
          sel_r <= sel;
          vi    <= tbl[idx];
          vj    <= tbl[sel];
          state <= S_WR;
        end
        S_WR: state <= S_RD;
        default: state <= S_IDLE;
      endcase
      if (advance) begin
        idx <= idx + 1'b1;
        if (at_end) begin
          if (pass == 2'd2) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            pass <= pass + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_INIT) tbl[idx] <= idx;
    if (state == S_WR) begin
      tbl[idx]   <= vj;
      tbl[sel_r] <= vi;
    end
    tbl_data <= tbl[tbl_addr];
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_swap_two_cycles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR) |=> (state == S_RD || done));

  assert_skip_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && sel == idx && !at_end) |=> (state == S_RD && idx == W'($past(idx) + 1'b1)));

  assert_run_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (state == S_INIT && idx == '0));
endmodule

// File: tb/sim_perm_swap_builder.sv
`timescale 1ns/1ps
module sim_perm_swap_builder;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done;
  logic [7:0] c_addr, c_data, b_addr, b_data, a_addr, a_data, tbl_addr, tbl_data;
  logic [7:0] cm [256];
  logic [7:0] bm [256];
  logic [7:0] am [256];
  logic [7:0] ref_t [256];
  int seen [256];
  logic [39:0] q [$];
  int checks = 0, fails = 0, cyc = 0, swaps = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign c_data = cm[c_addr];
  assign b_data = bm[b_addr];
  assign a_data = am[a_addr];

  perm_swap_builder #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .c_addr(c_addr), .c_data(c_data), .b_addr(b_addr), .b_data(b_data),
    .a_addr(a_addr), .a_data(a_data), .tbl_addr(tbl_addr), .tbl_data(tbl_data));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_pass(input int p);
    for (int i = 0; i < 256; i++) begin
      int j;
      logic [7:0] t;
      j = (p == 0) ? cm[i] : (p == 1) ? bm[i] : am[i];
      if (j != i) begin
        t = ref_t[i]; ref_t[i] = ref_t[j]; ref_t[j] = t;
        swaps++;
      end
    end
  endtask

  task automatic build_ref();
    swaps = 0;
    for (int i = 0; i < 256; i++) ref_t[i] = 8'(i);
    for (int p = 0; p < 3; p++) ref_pass(p);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && int'(q[0][39:8]) < cyc) begin
      logic [39:0] e;
      e = q.pop_front();
      chk("R3/R8 table entry", tbl_data, e[7:0]);
      seen[tbl_data]++;
    end
  end

  task automatic read_table();
    for (int v = 0; v < 256; v++) seen[v] = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      tbl_addr = 8'(k);
      q.push_back({32'(cyc), ref_t[k]});
    end
    @(negedge clk);
    @(negedge clk);
    begin
      int bad;
      bad = 0;
      for (int v = 0; v < 256; v++) if (seen[v] != 1) bad++;
      chk("R7 values not seen exactly once", bad, 0);
    end
  endtask

  task automatic run(input string tag, input int poke_at);
    int cnt;
    build_ref();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", busy, 1);
    cnt = 0;
    while (!done && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      start = (cnt == poke_at);
      if (!done && cnt > 1) chk("R2 busy during run", busy, 1);
    end
    start = 1'b0;
    chk({"R4 run latency ", tag}, cnt, 1024 + swaps);
    chk("R5 busy low with done", busy, 0);
    @(negedge clk);
    chk("R5 done single pulse", done, 0);
    read_table();
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tbl_addr = '0;
    for (int i = 0; i < 256; i++) begin cm[i] = 8'(i); bm[i] = 8'(i); am[i] = 8'(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);

    run("identity R4 skips", 0);

    for (int i = 0; i < 256; i++) cm[i] = 8'(255 - i);
    run("reverse C", 0);

    for (int i = 0; i < 256; i++) begin cm[i] = 8'(i); bm[i] = 8'(i); am[i] = 8'(i); end
    cm[0] = 8'd1; bm[0] = 8'd2; am[1] = 8'd3;
    run("pass order R3", 0);

    begin
      logic [15:0] s;
      s = 16'hACE1;
      for (int i = 0; i < 256; i++) begin
        s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; cm[i] = s[7:0];
        s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; bm[i] = s[9:2];
        s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; am[i] = s[15:8];
      end
    end
    run("random", 0);
    run("R9 rerun R6 start while busy", 100);
    run("R6 start in pass", 700);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule